// File: doc/BRIEF.md
# Three-Phase Center-Aligned PWM Generator

This block drives a three-phase inverter bridge. An up/down timebase counts from zero up to a programmed half-period and back down, so one switching period lasts twice the half-period value in clock cycles. For example, a 20 MHz clock with a half-period of 1000 gives a 10 kHz switching frequency. Each of the three legs compares the counter against its own duty value. It drives a complementary high-side/low-side pair that is symmetric about the middle of the period. Both edges of each active interval are trimmed by a programmable dead time.

Configuration arrives on plain input buses: half-period, dead time, sync width, three duty values and the update-mode bit. These buses act as staging values. They are copied into the working set only at reload points: the start of every period, and also mid-period when double update mode is selected. Each period begins with a sync pulse of programmable width and a one-cycle interrupt request. A status output tells which half of the period is running. A synchronous trip input from an external shutdown controller turns every output off and parks the timebase.

Top module: `tri_pwm_gen`

## Requirements
- R1: A period lasts 2*P clock cycles, where P is the loaded half-period. The counter counts up for P cycles and down for P cycles. A half-period value of 0 is taken as 1, giving a period of 2 cycles.
- R2: `second_half_o` is 0 for the first P cycles of a period and 1 for the last P cycles.
- R3: `irq_o` is high for exactly the first cycle of each period. `sync_o` is high for the first W cycles of each period, where W is the loaded sync width. A width of 0 is taken as 1.
- R4: Number the cycles of a period i = 0 .. 2P-1, with i = 0 on the `irq_o` cycle. Let Dc = min(D, P) and Dh = Dc - DT when Dc > DT, else 0. A high output is on exactly for P-Dh <= i < P+Dh. It is therefore never on when D <= DT.
- R5: With Dl = min(Dc + DT, P), a low output is on exactly for i < P-Dl or i >= P+Dl. It is therefore never on when D + DT >= P.
- R6: The high and low outputs of a leg are never on together. When neither saturates, there are 2*DT off cycles between the low output turning off and the high output turning on.
- R7: The trip input (`trip_i`) works as follows:
  - While `trip_i` is high, from the next cycle on, all PWM outputs, `sync_o`, `irq_o` and `second_half_o` are 0.
  - The first cycle after `trip_i` falls is the start of a period, with `irq_o` and `sync_o` high.
  - That period uses the configuration present on the input buses at the release edge.
- R8: In single update mode (`dbl_upd_i` = 0), input changes made during a period do not alter that period. They take effect from the next period start.
- R9: In double update mode (`dbl_upd_i` = 1), half-period, dead time and duty values are also reloaded at mid-period. The second half then lasts the new P cycles, and the duty compares in that half use the new values.
- R10: While `rst_n` is low, all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; one tick per cycle |
| rst_n | input | 1 | Asynchronous active-low reset |
| trip_i | input | 1 | Synchronous shutdown from the shutdown controller |
| half_per_i | input | CNT_W | Staged half-period in clock ticks |
| dead_i | input | DT_W | Staged dead time in clock ticks |
| sync_w_i | input | SW_W | Staged sync pulse width in clock ticks |
| duty_i | input | NCH*CNT_W | Staged duty values; leg k at bits [k*CNT_W +: CNT_W] |
| dbl_upd_i | input | 1 | 1 = double update mode, 0 = single update mode |
| pwm_hi_o | output | NCH | High-side drive per leg, active high |
| pwm_lo_o | output | NCH | Low-side drive per leg, active high |
| sync_o | output | 1 | Period sync pulse |
| irq_o | output | 1 | One-cycle interrupt request at each period start |
| second_half_o | output | 1 | 1 while the counter counts down |

## Verification
The bench builds the block with its default parameters: 16-bit counter and duties, 10-bit dead time, 8-bit sync width and three legs. It drives half-periods of 0, 10, 12 and 20 ticks, so every period fits in a few dozen captured cycles. Those small values still reach all the cases of interest in one run:
- a duty at or below the dead time;
- a duty equal to the half-period, which saturates the low side;
- the zero-period and zero-width clamps;
- a mid-period reload that shortens the down-count in double update mode.

// File: rtl/pwm_pkg.sv
package pwm_pkg;

    typedef enum logic {
        DIR_UP   = 1'b0,
        DIR_DOWN = 1'b1
    } cnt_dir_e;

endpackage

// File: rtl/pwm_timebase.sv
module pwm_timebase
    import pwm_pkg::*;
#(
    parameter int CNT_W = 16,
    parameter int DT_W  = 10,
    parameter int SW_W  = 8,
    parameter int NCH   = 3
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 trip_i,
    input  logic [CNT_W-1:0]     per_i,
    input  logic [DT_W-1:0]      dt_i,
    input  logic [SW_W-1:0]      sw_i,
    input  logic [NCH*CNT_W-1:0] duty_i,
    input  logic                 dbl_i,
    output logic [CNT_W-1:0]     cnt_o,
    output cnt_dir_e             dir_o,
    output logic                 run_o,
    output logic [CNT_W-1:0]     per_o,
    output logic [DT_W-1:0]      dt_o,
    output logic [NCH*CNT_W-1:0] duty_o,
    output logic                 sync_o,
    output logic                 irq_o
);

    localparam logic [CNT_W-1:0] CNT_ONE = {{(CNT_W-1){1'b0}}, 1'b1};
    localparam logic [SW_W-1:0]  SW_ONE  = {{(SW_W-1){1'b0}}, 1'b1};

    typedef struct packed {
        logic [CNT_W-1:0]     cnt;
        cnt_dir_e             dir;
        logic                 run;
        logic                 irq;
        logic [SW_W-1:0]      swc;
        logic                 dbl;
        logic [CNT_W-1:0]     per;
        logic [DT_W-1:0]      dt;
        logic [NCH*CNT_W-1:0] duty;
    } tbase_t;

    tbase_t s_d, s_q;

    logic [CNT_W-1:0] per_in;
    logic [SW_W-1:0]  sw_in;
    logic             at_start;
    logic             at_mid;

    always_comb begin
        per_in   = (per_i == '0) ? CNT_ONE : per_i;
        sw_in    = (sw_i == '0) ? SW_ONE : sw_i;
        at_start = !s_q.run || (s_q.dir == DIR_DOWN && s_q.cnt == CNT_ONE);
        at_mid   = s_q.run && s_q.dir == DIR_UP && (s_q.cnt >= s_q.per - CNT_ONE);

        s_d     = s_q;
        s_d.irq = 1'b0;
        if (s_q.swc != '0) begin
            s_d.swc = s_q.swc - SW_ONE;
        end

        if (trip_i || at_start) begin
            s_d.cnt  = '0;
            s_d.dir  = DIR_UP;
            s_d.per  = per_in;
            s_d.dt   = dt_i;
            s_d.duty = duty_i;
            s_d.dbl  = dbl_i;
            if (trip_i) begin
                s_d.run = 1'b0;
                s_d.swc = '0;
            end else begin
                s_d.run = 1'b1;
                s_d.irq = 1'b1;
                s_d.swc = sw_in;
            end
        end else if (at_mid) begin
            s_d.dir = DIR_DOWN;
            if (s_q.dbl) begin
                s_d.cnt  = per_in;
                s_d.per  = per_in;
                s_d.dt   = dt_i;
                s_d.duty = duty_i;
            end else begin
                s_d.cnt = s_q.per;
            end
        end else if (s_q.dir == DIR_UP) begin
            s_d.cnt = s_q.cnt + CNT_ONE;
        end else begin
            s_d.cnt = s_q.cnt - CNT_ONE;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign cnt_o  = s_q.cnt;
    assign dir_o  = s_q.dir;
    assign run_o  = s_q.run;
    assign per_o  = s_q.per;
    assign dt_o   = s_q.dt;
    assign duty_o = s_q.duty;
    assign sync_o = s_q.run && (s_q.swc != '0);
    assign irq_o  = s_q.irq;

    // R1: the running counter never passes the loaded half-period
    p_cnt_bound_r1: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.run |-> (s_q.cnt <= s_q.per));

    // R1: the end of the down-count wraps to a new up-count from zero
    p_wrap_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.run && s_q.dir == DIR_DOWN && s_q.cnt == CNT_ONE && !trip_i)
        |=> (s_q.cnt == '0 && s_q.dir == DIR_UP && irq_o));

    // R3: the interrupt cycle always falls inside the sync pulse
    p_irq_in_sync_r3: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> sync_o);

    // R7: a trip parks the counter at zero on the next cycle
    p_trip_park_r7: assert property (@(posedge clk) disable iff (!rst_n)
        trip_i |=> (!s_q.run && s_q.cnt == '0));

    // R8: in single update mode, mid-period leaves the working set alone
    p_single_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (at_mid && !s_q.dbl && !trip_i) |=> ($stable(s_q.per) && $stable(s_q.duty)));

endmodule

// File: rtl/pwm_leg.sv
module pwm_leg
    import pwm_pkg::*;
#(
    parameter int CNT_W = 16,
    parameter int DT_W  = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] cnt_i,
    input  cnt_dir_e         dir_i,
    input  logic             run_i,
    input  logic [CNT_W-1:0] per_i,
    input  logic [DT_W-1:0]  dt_i,
    input  logic [CNT_W-1:0] duty_i,
    output logic             hi_o,
    output logic             lo_o
);

    localparam int EW = CNT_W + 1;

    logic [CNT_W-1:0] duty_c;
    logic [CNT_W-1:0] dt_x;
    logic [EW-1:0]    on_w;
    logic [EW-1:0]    off_w;
    logic [EW-1:0]    off_sum;

    function automatic logic reached(input logic [CNT_W-1:0] c,
                                     input cnt_dir_e         d,
                                     input logic [CNT_W-1:0] p,
                                     input logic [EW-1:0]    w);
        logic [EW-1:0] s;
        s = {1'b0, c} + w;
        if (d == DIR_UP) begin
            return s >= {1'b0, p};
        end
        return s > {1'b0, p};
    endfunction

    always_comb begin
        dt_x    = CNT_W'(dt_i);
        duty_c  = (duty_i > per_i) ? per_i : duty_i;
        on_w    = (duty_c > dt_x) ? {1'b0, duty_c - dt_x} : '0;
        off_sum = {1'b0, duty_c} + {1'b0, dt_x};
        off_w   = (off_sum > {1'b0, per_i}) ? {1'b0, per_i} : off_sum;
        hi_o    = run_i && reached(cnt_i, dir_i, per_i, on_w);
        lo_o    = run_i && !reached(cnt_i, dir_i, per_i, off_w);
    end

    // R6: a complementary pair is never driven together
    p_no_overlap_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !(hi_o && lo_o));

    // R6: with nonzero dead time the low side is still off as the high side drops
    p_dead_gap_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(hi_o) && dt_i != '0) |-> !lo_o);

endmodule

// File: rtl/tri_pwm_gen.sv
module tri_pwm_gen
    import pwm_pkg::*;
#(
    parameter int CNT_W = 16,
    parameter int DT_W  = 10,
    parameter int SW_W  = 8,
    parameter int NCH   = 3
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 trip_i,
    input  logic [CNT_W-1:0]     half_per_i,
    input  logic [DT_W-1:0]      dead_i,
    input  logic [SW_W-1:0]      sync_w_i,
    input  logic [NCH*CNT_W-1:0] duty_i,
    input  logic                 dbl_upd_i,
    output logic [NCH-1:0]       pwm_hi_o,
    output logic [NCH-1:0]       pwm_lo_o,
    output logic                 sync_o,
    output logic                 irq_o,
    output logic                 second_half_o
);

    logic [CNT_W-1:0]     cnt_w;
    cnt_dir_e             dir_w;
    logic                 run_w;
    logic [CNT_W-1:0]     per_w;
    logic [DT_W-1:0]      dt_w;
    logic [NCH*CNT_W-1:0] duty_w;

    pwm_timebase #(
        .CNT_W(CNT_W), .DT_W(DT_W), .SW_W(SW_W), .NCH(NCH)
    ) u_tbase (
        .clk    (clk),
        .rst_n  (rst_n),
        .trip_i (trip_i),
        .per_i  (half_per_i),
        .dt_i   (dead_i),
        .sw_i   (sync_w_i),
        .duty_i (duty_i),
        .dbl_i  (dbl_upd_i),
        .cnt_o  (cnt_w),
        .dir_o  (dir_w),
        .run_o  (run_w),
        .per_o  (per_w),
        .dt_o   (dt_w),
        .duty_o (duty_w),
        .sync_o (sync_o),
        .irq_o  (irq_o)
    );

    for (genvar g = 0; g < NCH; g++) begin : g_leg
        pwm_leg #(
            .CNT_W(CNT_W), .DT_W(DT_W)
        ) u_leg (
            .clk    (clk),
            .rst_n  (rst_n),
            .cnt_i  (cnt_w),
            .dir_i  (dir_w),
            .run_i  (run_w),
            .per_i  (per_w),
            .dt_i   (dt_w),
            .duty_i (duty_w[g*CNT_W +: CNT_W]),
            .hi_o   (pwm_hi_o[g]),
            .lo_o   (pwm_lo_o[g])
        );
    end

    assign second_half_o = run_w && (dir_w == DIR_DOWN);

    // R7: one cycle after a trip request every output is quiet
    p_trip_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
        trip_i |=> (pwm_hi_o == '0 && pwm_lo_o == '0 && !sync_o && !irq_o && !second_half_o));

    // R2: the half flag rises only after the interrupt cycle has passed
    p_half_after_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> !second_half_o);

endmodule

// File: tb/tb_tri_pwm_gen.sv
module tb_tri_pwm_gen;

    localparam int CNT_W = 16;
    localparam int DT_W  = 10;
    localparam int SW_W  = 8;
    localparam int NCH   = 3;

    logic                 clk = 1'b0;
    logic                 rst_n = 1'b0;
    logic                 trip_i = 1'b1;
    logic [CNT_W-1:0]     half_per_i = '0;
    logic [DT_W-1:0]      dead_i = '0;
    logic [SW_W-1:0]      sync_w_i = '0;
    logic [NCH*CNT_W-1:0] duty_i = '0;
    logic                 dbl_upd_i = 1'b0;
    logic [NCH-1:0]       pwm_hi_o;
    logic [NCH-1:0]       pwm_lo_o;
    logic                 sync_o;
    logic                 irq_o;
    logic                 second_half_o;

    int n_checks = 0;
    int n_errors = 0;

    logic [NCH-1:0] hi_s [0:127];
    logic [NCH-1:0] lo_s [0:127];
    logic           sy_s [0:127];
    logic           hf_s [0:127];
    logic           iq_s [0:127];

    always #2 clk = ~clk;

    tri_pwm_gen #(
        .CNT_W(CNT_W), .DT_W(DT_W), .SW_W(SW_W), .NCH(NCH)
    ) dut (
        .clk           (clk),
        .rst_n         (rst_n),
        .trip_i        (trip_i),
        .half_per_i    (half_per_i),
        .dead_i        (dead_i),
        .sync_w_i      (sync_w_i),
        .duty_i        (duty_i),
        .dbl_upd_i     (dbl_upd_i),
        .pwm_hi_o      (pwm_hi_o),
        .pwm_lo_o      (pwm_lo_o),
        .sync_o        (sync_o),
        .irq_o         (irq_o),
        .second_half_o (second_half_o)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic set_cfg(input int p, input int dt, input int w,
                           input int d0, input int d1, input int d2, input bit dbl);
        half_per_i = CNT_W'(p);
        dead_i     = DT_W'(dt);
        sync_w_i   = SW_W'(w);
        duty_i     = {CNT_W'(d2), CNT_W'(d1), CNT_W'(d0)};
        dbl_upd_i  = dbl;
    endtask

    // trip pulse loads the staged configuration; returns on the first running cycle
    task automatic load_by_trip();
        trip_i = 1'b1;
        repeat (2) @(negedge clk);
        trip_i = 1'b0;
        @(negedge clk);
    endtask

    task automatic capture(input int n);
        for (int i = 0; i < n; i++) begin
            hi_s[i] = pwm_hi_o;
            lo_s[i] = pwm_lo_o;
            sy_s[i] = sync_o;
            hf_s[i] = second_half_o;
            iq_s[i] = irq_o;
            @(negedge clk);
        end
    endtask

    // compare one leg over one single-mode period starting at index base
    task automatic chk_leg(input int base, input int ch, input int p, input int dt,
                           input int d, input string tag);
        int dc, dh, dl, mh, ml;
        dc = (d > p) ? p : d;
        dh = (dc > dt) ? dc - dt : 0;
        dl = (dc + dt > p) ? p : dc + dt;
        mh = 0;
        ml = 0;
        for (int i = 0; i < 2*p; i++) begin
            if (hi_s[base+i][ch] !== ((i >= p - dh) && (i < p + dh))) mh++;
            if (lo_s[base+i][ch] !== ((i < p - dl) || (i >= p + dl))) ml++;
        end
        chk(mh == 0, {tag, " R4 high-side pattern mismatches"}, mh, 0);
        chk(ml == 0, {tag, " R5 low-side pattern mismatches"}, ml, 0);
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk(pwm_hi_o == '0 && pwm_lo_o == '0, "R10 pwm outputs in reset",
            int'({pwm_hi_o, pwm_lo_o}), 0);
        chk(!sync_o && !irq_o && !second_half_o, "R10 status outputs in reset",
            int'({sync_o, irq_o, second_half_o}), 0);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic t_basic();
        int nirq, nhalf, nsync, badhalf, ovl, fh, ll;
        set_cfg(20, 3, 5, 8, 2, 20, 1'b0);
        load_by_trip();
        capture(41);
        nirq = 0; nhalf = 0; nsync = 0; badhalf = 0; ovl = 0;
        for (int i = 0; i < 40; i++) begin
            nirq += int'(iq_s[i]);
            nhalf += int'(hf_s[i]);
            if (hf_s[i] !== (i >= 20)) badhalf++;
            if (sy_s[i] !== (i < 5)) nsync++;
            for (int c = 0; c < NCH; c++) if (hi_s[i][c] && lo_s[i][c]) ovl++;
        end
        chk(iq_s[0] === 1'b1 && nirq == 1, "R3 single irq at period start", nirq, 1);
        chk(iq_s[40] === 1'b1, "R1 next period starts after 2P cycles", int'(iq_s[40]), 1);
        chk(nhalf == 20 && badhalf == 0, "R2 second half flag", nhalf, 20);
        chk(nsync == 0, "R3 sync width mismatches", nsync, 0);
        chk_leg(0, 0, 20, 3, 8, "leg0");
        chk_leg(0, 1, 20, 3, 2, "leg1 duty<=dt");
        chk_leg(0, 2, 20, 3, 20, "leg2 duty=P");
        chk(ovl == 0, "R6 overlap cycles", ovl, 0);
        fh = -1; ll = -1;
        for (int i = 0; i < 20; i++) begin
            if (lo_s[i][0]) ll = i;
            if (hi_s[i][0] && fh < 0) fh = i;
        end
        chk(fh - ll - 1 == 6, "R6 dead gap equals 2*DT", fh - ll - 1, 6);
    endtask

    task automatic t_clamp();
        int bad;
        set_cfg(0, 0, 0, 0, 0, 0, 1'b0);
        load_by_trip();
        capture(6);
        bad = 0;
        for (int i = 0; i < 6; i++) begin
            if (iq_s[i] !== (i % 2 == 0)) bad++;
            if (hf_s[i] !== (i % 2 == 1)) bad++;
        end
        chk(bad == 0, "R1 zero half-period runs as 2-cycle period", bad, 0);
        chk(sy_s[0] === 1'b1 && sy_s[1] === 1'b0, "R3 zero sync width runs as 1",
            int'({sy_s[0], sy_s[1]}), 2);
    endtask

    task automatic t_shadow();
        int nirq, bad;
        set_cfg(20, 3, 5, 8, 2, 20, 1'b0);
        load_by_trip();
        for (int i = 0; i < 61; i++) begin
            hi_s[i] = pwm_hi_o;
            lo_s[i] = pwm_lo_o;
            hf_s[i] = second_half_o;
            iq_s[i] = irq_o;
            if (i == 5) set_cfg(10, 3, 5, 14, 2, 20, 1'b0);
            @(negedge clk);
        end
        chk_leg(0, 0, 20, 3, 8, "R8 current period unchanged leg0");
        nirq = 0;
        for (int i = 1; i < 40; i++) nirq += int'(iq_s[i]);
        chk(nirq == 0 && iq_s[40] === 1'b1, "R8 old period length kept", nirq, 0);
        chk_leg(40, 0, 10, 3, 14, "R8 new period leg0");
        bad = 0;
        for (int i = 40; i < 60; i++) if (hf_s[i] !== (i >= 50)) bad++;
        chk(bad == 0 && iq_s[60] === 1'b1, "R8 new half-period applied", bad, 0);
    endtask

    task automatic t_double();
        int bh, bl, bf;
        set_cfg(20, 3, 5, 8, 2, 20, 1'b1);
        load_by_trip();
        for (int i = 0; i < 34; i++) begin
            hi_s[i] = pwm_hi_o;
            lo_s[i] = pwm_lo_o;
            hf_s[i] = second_half_o;
            iq_s[i] = irq_o;
            if (i == 3) set_cfg(12, 3, 5, 6, 2, 20, 1'b1);
            @(negedge clk);
        end
        bh = 0; bl = 0; bf = 0;
        for (int i = 0; i < 32; i++) begin
            if (hi_s[i][0] !== (i >= 15 && i <= 22)) bh++;
            if (lo_s[i][0] !== (i < 9 || i >= 29)) bl++;
            if (hf_s[i] !== (i >= 20)) bf++;
        end
        chk(bh == 0, "R9 high side uses new duty in second half", bh, 0);
        chk(bl == 0, "R9 low side uses new duty in second half", bl, 0);
        chk(bf == 0 && iq_s[32] === 1'b1, "R9 second half lasts new P", bf, 0);
    endtask

    task automatic t_trip();
        set_cfg(20, 3, 5, 8, 2, 20, 1'b0);
        load_by_trip();
        repeat (25) @(negedge clk);
        trip_i = 1'b1;
        @(negedge clk);
        chk(pwm_hi_o == '0 && pwm_lo_o == '0, "R7 pwm off after trip",
            int'({pwm_hi_o, pwm_lo_o}), 0);
        chk(!sync_o && !irq_o && !second_half_o, "R7 status off after trip",
            int'({sync_o, irq_o, second_half_o}), 0);
        set_cfg(10, 1, 3, 5, 2, 20, 1'b0);
        repeat (2) @(negedge clk);
        chk(pwm_lo_o == '0, "R7 outputs stay off while tripped", int'(pwm_lo_o), 0);
        trip_i = 1'b0;
        @(negedge clk);
        chk(irq_o && sync_o && !second_half_o, "R7 period start on release",
            int'({irq_o, sync_o, second_half_o}), 6);
        capture(21);
        chk_leg(0, 0, 10, 1, 5, "R7 release config leg0");
        chk(iq_s[20] === 1'b1, "R7 release half-period in effect", int'(iq_s[20]), 1);
    endtask

    task automatic finish_run();
        $display("CHECKS %0d ERRORS %0d", n_checks, n_errors);
        $finish;
    endtask

    initial begin
        #(4 * 150000);
        n_checks++;
        n_errors++;
        $display("FAIL watchdog R1-R10 run actual=timeout expected=done");
        finish_run();
    end

    initial begin
        t_reset();
        t_basic();
        t_clamp();
        t_shadow();
        t_double();
        t_trip();
        finish_run();
    end

endmodule